// File: doc/BRIEF.md
# Pipelined Expanded-Sum Datapath

This block evaluates a loop kernel whose every output has been expanded into the same closed form. Result number k is `(a*k + b*k + c*k + d*k) >> 8`. The four data operands are shared by all outputs. Only the index k changes from one output to the next, and k is itself a multiplier operand. Operand sets for successive outputs enter one after another. Each set carries a valid bit and its index through registered multiply, add and shift stages, and leaves with that index as a tag.

A mode input selects one of two configurations. In the wide configuration, four products are formed at once. A two-level adder tree sums them, and a last stage shifts the sum. One operand set is accepted per cycle. In the folded configuration, only a two-product partial-sum path is used. It is applied first to (a, b) and then to (c, d). The first partial result is parked. A final stage adds the two partials and shifts the sum. Input is then taken on alternate cycles only. The mode is latched only while nothing is in flight.

Top module: `kernel_sum_pipe`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1 and `fold_active` is 0 (wide mode).
- R2: In wide mode, every result equals `(k*(a+b+c+d)) >> 8`, where k is `in_idx`. The sum is kept to 13 bits before the shift, so inputs of 255 with k=7 give 27.
- R3: In wide mode, an operand set accepted at clock edge N appears on `out_valid`/`out_val` just after edge N+3 (4 stages). `out_idx` carries the index it was given.
- R4: In wide mode, `in_ready` stays 1. Sets offered on consecutive cycles give results on consecutive cycles, in the same order.
- R5: In folded mode, every result equals the same value as in R2. It is built from the partial sums a*k+b*k and c*k+d*k, which are added and then shifted right by 8.
- R6: In folded mode, `in_ready` is 0 in the cycle right after a set is accepted. A set offered during that cycle is ignored and yields no result.
- R7: In folded mode, a set accepted at edge N also appears just after edge N+3, tagged with its index.
- R8: `fold_active` takes the value of `fold_mode` only at an edge where no set is in flight and none is being accepted. A request made while data is in flight takes effect once the pipeline has drained.
- R9: Cycles without an accepted set produce no result: `out_valid` stays 0 for them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fold_mode | input | 1 | Requested mode: 1 folded, 0 wide |
| in_valid | input | 1 | Operand set offered |
| in_ready | output | 1 | Block can take a set this cycle |
| in_idx | input | 3 | Output index k, also a multiplier operand |
| in_a | input | 8 | Shared operand a (unsigned) |
| in_b | input | 8 | Shared operand b (unsigned) |
| in_c | input | 8 | Shared operand c (unsigned) |
| in_d | input | 8 | Shared operand d (unsigned) |
| out_valid | output | 1 | Result present |
| out_idx | output | 3 | Index tag of the result |
| out_val | output | 5 | Shifted result |
| fold_active | output | 1 | Mode currently in effect |

## Verification
The assertions assume that `in_valid` is low while reset is held. They also assume a set is counted only when both `in_valid` and `in_ready` are high. Under those conditions, a four-cycle lookback relates each tagged result to the accepted set. The stimulus changes inputs only on falling edges. It asserts `in_valid` during the blocked folded cycle only to probe R6. It requests a mode change while a set is in flight, to show that the latched mode stays put until the pipeline drains.

// File: rtl/kernel_sum_pipe.sv
module kernel_sum_pipe #(
  parameter int DW    = 8,
  parameter int IW    = 3,
  parameter int SHIFT = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fold_mode,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [IW-1:0] in_idx,
  input  logic [DW-1:0] in_a,
  input  logic [DW-1:0] in_b,
  input  logic [DW-1:0] in_c,
  input  logic [DW-1:0] in_d,
  output logic          out_valid,
  output logic [IW-1:0] out_idx,
  output logic [DW+IW+2-SHIFT-1:0] out_val,
  output logic          fold_active
);
  localparam int PW = DW + IW;
  localparam int HW = PW + 1;
  localparam int SW = PW + 2;
  localparam int OW = SW - SHIFT;

  logic          fold_q, issue2;
  logic          v1, v2, v3, fin1, fin2;
  logic [IW-1:0] idx_h, idx1, idx2, idx3;
  logic [DW-1:0] hold_c, hold_d;
  logic [PW-1:0] p0, p1, p2, p3;
  logic [HW-1:0] s2a, s2b, part_q;
  logic [SW-1:0] t3;

  wire          accept = in_valid && in_ready;
  wire          busy   = v1 || v2 || v3 || issue2;
  wire [DW-1:0] mx     = issue2 ? hold_c : in_a;
  wire [DW-1:0] my     = issue2 ? hold_d : in_b;
  wire [IW-1:0] kx     = issue2 ? idx_h  : in_idx;
  wire [SW-1:0] fsum   = SW'(part_q) + SW'(s2a);

  assign in_ready    = !issue2;
  assign fold_active = fold_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fold_q <= 1'b0;  issue2 <= 1'b0;
      v1 <= 1'b0;  v2 <= 1'b0;  v3 <= 1'b0;
      fin1 <= 1'b0;  fin2 <= 1'b0;
      idx_h <= '0;  idx1 <= '0;  idx2 <= '0;  idx3 <= '0;
      hold_c <= '0;  hold_d <= '0;
      p0 <= '0;  p1 <= '0;  p2 <= '0;  p3 <= '0;
      s2a <= '0;  s2b <= '0;  part_q <= '0;  t3 <= '0;
      out_valid <= 1'b0;  out_idx <= '0;  out_val <= '0;
    end else begin
      if (!busy && !accept) fold_q <= fold_mode;
      issue2 <= fold_q && accept;
      if (fold_q && accept) begin
        hold_c <= in_c;
        hold_d <= in_d;
        idx_h  <= in_idx;
      end
      // stage 1: products
      v1   <= accept || issue2;
      fin1 <= !fold_q || issue2;
      idx1 <= kx;
      p0   <= PW'(mx)   * PW'(kx);
      p1   <= PW'(my)   * PW'(kx);
      p2   <= PW'(in_c) * PW'(in_idx);
      p3   <= PW'(in_d) * PW'(in_idx);
      // stage 2: pair sums
      v2   <= v1;
      fin2 <= fin1;
      idx2 <= idx1;
      s2a  <= HW'(p0) + HW'(p1);
      s2b  <= HW'(p2) + HW'(p3);
      // stage 3: full sum (wide) / parked partial (folded)
      if (v2 && !fin2) part_q <= s2a;
      v3   <= v2 && !fold_q;
      idx3 <= idx2;
      t3   <= SW'(s2a) + SW'(s2b);
      // stage 4: shift, or combine-and-shift when folded
      if (fold_q) begin
        out_valid <= v2 && fin2;
        out_idx   <= idx2;
        out_val   <= OW'(fsum >> SHIFT);
      end else begin
        out_valid <= v3;
        out_idx   <= idx3;
        out_val   <= OW'(t3 >> SHIFT);
      end
    end
  end

  assert_wide_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !fold_q |-> in_ready);

  assert_fold_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fold_q && accept) |=> !in_ready);

  assert_mode_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(fold_q));

  assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(accept, 4));

  assert_tag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_idx == $past(in_idx, 4)));
endmodule

// File: tb/kernel_sum_pipe_tb.sv
`timescale 1ns/1ps
module kernel_sum_pipe_tb;
  logic clk = 1'b0, rst_n = 1'b0, fold_mode = 1'b0, in_valid = 1'b0;
  logic in_ready, out_valid, fold_active;
  logic [2:0] in_idx = '0, out_idx;
  logic [7:0] in_a = '0, in_b = '0, in_c = '0, in_d = '0;
  logic [4:0] out_val;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  kernel_sum_pipe u_dut (.clk(clk), .rst_n(rst_n), .fold_mode(fold_mode),
    .in_valid(in_valid), .in_ready(in_ready), .in_idx(in_idx), .in_a(in_a),
    .in_b(in_b), .in_c(in_c), .in_d(in_d), .out_valid(out_valid),
    .out_idx(out_idx), .out_val(out_val), .fold_active(fold_active));

  localparam int N = 8;
  localparam logic [34:0] VEC [N] = '{
    {3'd1,  8'd10,  8'd20,  8'd30,  8'd40},
    {3'd2, 8'd100, 8'd120,  8'd90,  8'd60},
    {3'd3, 8'd200, 8'd100,  8'd50,  8'd10},
    {3'd4, 8'd255,   8'd0, 8'd255,   8'd0},
    {3'd5, 8'd255, 8'd255, 8'd255, 8'd255},
    {3'd7, 8'd255, 8'd255, 8'd255, 8'd255},
    {3'd0, 8'd200, 8'd200, 8'd200, 8'd200},
    {3'd6,  8'd17,  8'd99, 8'd180,  8'd33}
  };

  function automatic int expect_of(logic [34:0] v);
    return (int'(v[34:32]) * (int'(v[31:24]) + int'(v[23:16]) + int'(v[15:8]) + int'(v[7:0]))) >> 8;
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic [34:0] v);
    in_valid = 1'b1;
    {in_idx, in_a, in_b, in_c, in_d} = v;
  endtask

  task automatic check_result(input logic [34:0] v, input string req);
    check(out_valid === 1'b1, {req, " valid"}, int'(out_valid), 1);
    check(out_idx === v[34:32], {req, " tag"}, int'(out_idx), int'(v[34:32]));
    check(int'(out_val) == expect_of(v), {req, " value"}, int'(out_val), expect_of(v));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(out_valid === 1'b0, "R1 out_valid", int'(out_valid), 0);
    check(in_ready === 1'b1, "R1 in_ready", int'(in_ready), 1);
    check(fold_active === 1'b0, "R1 fold_active", int'(fold_active), 0);

    // R2 R3 R4 R9: wide mode, table streamed back to back
    for (int c = 0; c <= N + 4; c++) begin
      @(negedge clk);
      if (c >= 4 && c - 4 < N) check_result(VEC[c-4], "R2/R3/R4 wide stream");
      else check(out_valid === 1'b0, "R9 no result without input", int'(out_valid), 0);
      check(in_ready === 1'b1, "R4 ready in wide mode", int'(in_ready), 1);
      if (c < N) drive(VEC[c]); else in_valid = 1'b0;
    end

    // R3 latency: one set, nothing before edge N+3
    @(negedge clk); drive(VEC[2]);
    @(negedge clk); in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(out_valid === 1'b0, "R3 not before 4 stages", int'(out_valid), 0);
    @(negedge clk);
    check_result(VEC[2], "R3 single set");

    // R8: mode request arrives with an accepted set; applies only after drain
    @(negedge clk); drive(VEC[5]); fold_mode = 1'b1;
    @(negedge clk); in_valid = 1'b0;
    @(negedge clk);
    check(fold_active === 1'b0, "R8 held while in flight", int'(fold_active), 0);
    @(negedge clk);
    @(negedge clk);
    check_result(VEC[5], "R8 wide result before switch");
    check(fold_active === 1'b0, "R8 held at last stage", int'(fold_active), 0);
    @(negedge clk);
    check(fold_active === 1'b1, "R8 applied after drain", int'(fold_active), 1);

    // R5 R6 R7: folded mode, table at one set per two cycles
    for (int c = 0; c <= 2 * N + 4; c++) begin
      @(negedge clk);
      if (c >= 4 && (c % 2) == 0 && (c - 4) / 2 < N) check_result(VEC[(c-4)/2], "R5/R7 folded stream");
      else check(out_valid === 1'b0, "R9 folded idle slot", int'(out_valid), 0);
      if ((c % 2) == 1 && c < 2 * N) check(in_ready === 1'b0, "R6 ready low after accept", int'(in_ready), 0);
      if ((c % 2) == 0 && c < 2 * N) drive(VEC[c/2]); else in_valid = 1'b0;
    end

    // R6: a set offered in the blocked cycle is ignored
    @(negedge clk); drive(VEC[1]);
    @(negedge clk);
    check(in_ready === 1'b0, "R6 blocked cycle", int'(in_ready), 0);
    drive(VEC[7]);
    @(negedge clk); in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check_result(VEC[1], "R6 first set");
    @(negedge clk);
    check(out_valid === 1'b0, "R6 ignored set gives no result", int'(out_valid), 0);
    @(negedge clk);
    check(out_valid === 1'b0, "R6 ignored set gives no result", int'(out_valid), 0);

    // R8: back to wide while idle, then max-value check R2
    fold_mode = 1'b0;
    @(negedge clk);
    check(fold_active === 1'b0, "R8 switch when empty", int'(fold_active), 0);
    drive(VEC[5]);
    @(negedge clk); in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    check_result(VEC[5], "R2 full-scale sum");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all-requirements actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule